// File: doc/BRIEF.md
# Monochrome Framebuffer Scan-Out Serializer

This block turns a one-bit-per-pixel image into a pixel-rate colour stream locked to a video raster. The image sits in a synchronous dual-port RAM as packed 16-bit words. The block drives the read-only port of that RAM and takes the returned word. The raster timing generator supplies the horizontal and vertical pixel counters and an active-video flag. Every pixel clock, during active video, one bit leaves a shift register and becomes either pure green (bit 0) or pure blue (bit 1). Outside the active area the colour is black.

The word address is derived from the raster and not from a free-running count. It is forced to 0 on every vertically blanked line. It advances only when the first pixel of a word is consumed, and it runs contiguously from the end of one line into the next. A word is requested one clock before its first pixel, which covers the one-cycle read latency of the RAM. As a result the first word of each line is already on the read bus when pixel 0 arrives, and every frame starts at word 0, so the picture cannot roll. The default raster is 1440x900, which gives 90 words per line and 81000 words per frame. The logic is held in reset while the pixel-clock PLL is not locked.

Top module: `mono_scanout`

## Requirements
- R1: While `rst_n` is low, `rgb` is 0 and `rd_addr` is 0.
- R2: The colour for raster position (x, y) comes from bit x mod 16 of word y*(H_ACTIVE/16) + x/16. Bit 0 is the leftmost pixel of the word.
- R3: A pixel bit of 0 gives `rgb` = 24'h00FF00 (green) and a bit of 1 gives 24'h0000FF (blue), with bits 23:16 red, 15:8 green and 7:0 blue.
- R4: A clock after a cycle with `de` low, `rgb` is 24'h000000.
- R5: `rgb` shows the pixel whose counters were on `h_cnt`/`v_cnt` one clock earlier. The latency is exactly one cycle.
- R6: `rd_addr` never reaches H_ACTIVE*V_ACTIVE/16. After the last word of a frame it wraps to 0.
- R7: During horizontal blanking of an active line, `rd_addr` holds its value.
- R8: One clock after a cycle with `v_cnt` >= V_ACTIVE, `rd_addr` is 0.
- R9: The same raster position shows the same colour in every frame.
- R10: Pixel 0 of each line shows bit 0 of that line's first word, which was fetched during the preceding blanking.
- R11: After a reset released mid-frame, the image is correct from the first frame that begins after the next vertical blanking.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock, shared with the RAM |
| rst_n | input | 1 | Active-low asynchronous reset, low while the PLL is unlocked |
| h_cnt | input | HCNT_W | Horizontal pixel counter from the timing generator |
| v_cnt | input | VCNT_W | Vertical line counter from the timing generator |
| de | input | 1 | Active-video flag from the timing generator |
| rd_addr | output | ADDR_W | Word address to the RAM read port |
| rd_data | input | WORD_W | Read data, valid one clock after its address |
| rgb | output | 24 | Pixel colour: red 23:16, green 15:8, blue 7:0 |

## Verification
A stale or skipped word address shows up within one word time as a wrong colour. From then on, every active pixel of the frame is shifted by whole words. An address that fails to return to 0 shows up as an image displaced from the next frame onward. A shift register that loads one clock late, or that shifts during blanking, corrupts the first pixel of the affected word or line at once. The bench model compares colour on every clock and the read address at each blanking boundary, so a fault is caught in the cycle it first reaches a port. It also samples one fixed position across frames, which exposes any roll.

// File: rtl/mono_scanout_pkg.sv
package mono_scanout_pkg;

   typedef logic [23:0] rgb_t;

   localparam rgb_t RGB_BLACK = 24'h000000;
   localparam rgb_t RGB_GREEN = 24'h00FF00;
   localparam rgb_t RGB_BLUE  = 24'h0000FF;

endpackage

// File: rtl/msc_addr_gen.sv
module msc_addr_gen #(
   parameter int FRAME_WORDS = 81000,
   parameter int ADDR_W      = 17
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              vblank,
   input  logic              fetch,
   output logic [ADDR_W-1:0] addr
);

   localparam logic [ADDR_W-1:0] LAST_WORD = ADDR_W'(FRAME_WORDS - 1);

   // The address always points at the next word to consume, so the RAM
   // returns that word one clock before its first pixel is needed.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr <= '0;
      end else if (vblank) begin
         addr <= '0;
      end else if (fetch) begin
         addr <= (addr == LAST_WORD) ? '0 : addr + 1'b1;
      end
   end

endmodule

// File: rtl/msc_shifter.sv
module msc_shifter #(
   parameter int WORD_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              de,
   input  logic              word_start,
   input  logic [WORD_W-1:0] rd_data,
   output logic              pix_bit
);

   logic [WORD_W-1:0] sreg;

   // On the first pixel of a word the bit comes straight from the RAM;
   // the remaining bits are parked in the shift register.
   assign pix_bit = word_start ? rd_data[0] : sreg[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sreg <= '0;
      end else if (de) begin
         if (word_start) begin
            sreg <= {1'b0, rd_data[WORD_W-1:1]};
         end else begin
            sreg <= {1'b0, sreg[WORD_W-1:1]};
         end
      end
   end

endmodule

// File: rtl/msc_colour.sv
module msc_colour
   import mono_scanout_pkg::*;
#(
   parameter rgb_t OFF_RGB = RGB_GREEN,
   parameter rgb_t ON_RGB  = RGB_BLUE
) (
   input  logic clk,
   input  logic rst_n,
   input  logic de,
   input  logic pix_bit,
   output rgb_t rgb
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rgb <= RGB_BLACK;
      end else if (!de) begin
         rgb <= RGB_BLACK;
      end else begin
         rgb <= pix_bit ? ON_RGB : OFF_RGB;
      end
   end

endmodule

// File: rtl/mono_scanout.sv
module mono_scanout
   import mono_scanout_pkg::*;
#(
   parameter int   H_ACTIVE = 1440,
   parameter int   V_ACTIVE = 900,
   parameter int   WORD_W   = 16,
   parameter int   HCNT_W   = 11,
   parameter int   VCNT_W   = 10,
   parameter rgb_t OFF_RGB  = RGB_GREEN,
   parameter rgb_t ON_RGB   = RGB_BLUE,
   localparam int  LINE_WORDS  = H_ACTIVE / WORD_W,
   localparam int  FRAME_WORDS = LINE_WORDS * V_ACTIVE,
   localparam int  ADDR_W      = $clog2(FRAME_WORDS + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [HCNT_W-1:0] h_cnt,
   input  logic [VCNT_W-1:0] v_cnt,
   input  logic              de,
   output logic [ADDR_W-1:0] rd_addr,
   input  logic [WORD_W-1:0] rd_data,
   output logic [23:0]       rgb
);

   // Elaboration-time parameter checks
   if (WORD_W < 2) begin : g_chk_word
      $error("WORD_W must be at least 2");
   end
   if (H_ACTIVE % WORD_W != 0) begin : g_chk_line
      $error("H_ACTIVE must be a whole number of words");
   end
   if (H_ACTIVE >= (1 << HCNT_W)) begin : g_chk_hcnt
      $error("HCNT_W too narrow for H_ACTIVE");
   end
   if (V_ACTIVE >= (1 << VCNT_W)) begin : g_chk_vcnt
      $error("VCNT_W too narrow for V_ACTIVE");
   end

   logic word_start;
   logic vblank;
   logic fetch;
   logic pix_bit;
   rgb_t rgb_q;

   assign word_start = (h_cnt % HCNT_W'(WORD_W)) == '0;
   assign vblank     = v_cnt >= VCNT_W'(V_ACTIVE);
   assign fetch      = de & word_start;

   msc_addr_gen #(
      .FRAME_WORDS (FRAME_WORDS),
      .ADDR_W      (ADDR_W)
   ) u_addr (
      .clk    (clk),
      .rst_n  (rst_n),
      .vblank (vblank),
      .fetch  (fetch),
      .addr   (rd_addr)
   );

   msc_shifter #(
      .WORD_W (WORD_W)
   ) u_shift (
      .clk        (clk),
      .rst_n      (rst_n),
      .de         (de),
      .word_start (word_start),
      .rd_data    (rd_data),
      .pix_bit    (pix_bit)
   );

   msc_colour #(
      .OFF_RGB (OFF_RGB),
      .ON_RGB  (ON_RGB)
   ) u_colour (
      .clk     (clk),
      .rst_n   (rst_n),
      .de      (de),
      .pix_bit (pix_bit),
      .rgb     (rgb_q)
   );

   assign rgb = rgb_q;

endmodule

// File: rtl/mono_scanout_chk.sv
module mono_scanout_chk
   import mono_scanout_pkg::*;
#(
   parameter int   V_ACTIVE    = 900,
   parameter int   VCNT_W      = 10,
   parameter int   ADDR_W      = 17,
   parameter int   FRAME_WORDS = 81000,
   parameter rgb_t OFF_RGB     = RGB_GREEN,
   parameter rgb_t ON_RGB      = RGB_BLUE
) (
   input logic              clk,
   input logic              rst_n,
   input logic              de,
   input logic [VCNT_W-1:0] v_cnt,
   input logic [ADDR_W-1:0] rd_addr,
   input logic [23:0]       rgb
);

   AST_RESET_CLEAR: assert property (@(posedge clk)
      !rst_n |=> (rgb == RGB_BLACK && rd_addr == '0)); // R1

   AST_COLOUR_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      de |=> (rgb == OFF_RGB || rgb == ON_RGB)); // R3

   AST_BLANK_BLACK: assert property (@(posedge clk) disable iff (!rst_n)
      !de |=> rgb == RGB_BLACK); // R4

   AST_ADDR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      rd_addr < ADDR_W'(FRAME_WORDS)); // R6

   AST_HBLANK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!de && v_cnt < VCNT_W'(V_ACTIVE)) |=> $stable(rd_addr)); // R7

   AST_VBLANK_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (v_cnt >= VCNT_W'(V_ACTIVE)) |=> rd_addr == '0); // R8

endmodule

bind mono_scanout mono_scanout_chk #(
   .V_ACTIVE    (V_ACTIVE),
   .VCNT_W      (VCNT_W),
   .ADDR_W      (ADDR_W),
   .FRAME_WORDS (FRAME_WORDS),
   .OFF_RGB     (OFF_RGB),
   .ON_RGB      (ON_RGB)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .de      (de),
   .v_cnt   (v_cnt),
   .rd_addr (rd_addr),
   .rgb     (rgb)
);

// File: tb/test_mono_scanout.sv
`timescale 1ns/1ps
module test_mono_scanout;

   localparam int HA = 64;
   localparam int VA = 6;
   localparam int HT = 80;
   localparam int VT = 9;
   localparam int WW = 16;
   localparam int HW = 11;
   localparam int VW = 10;
   localparam int LW = HA / WW;
   localparam int FW = LW * VA;
   localparam int AW = $clog2(FW + 1);
   localparam int FRAME_CYC = HT * VT;

   logic          clk = 1'b0;
   logic          rst_n;
   logic [HW-1:0] h_cnt;
   logic [VW-1:0] v_cnt;
   logic          de;
   logic [AW-1:0] rd_addr;
   logic [WW-1:0] rd_data;
   logic [23:0]   rgb;

   int vectors  = 0;
   int failures = 0;
   bit done     = 1'b0;

   always #5 clk = ~clk;

   mono_scanout #(
      .H_ACTIVE (HA),
      .V_ACTIVE (VA),
      .WORD_W   (WW),
      .HCNT_W   (HW),
      .VCNT_W   (VW)
   ) i_mono_scanout (
      .clk     (clk),
      .rst_n   (rst_n),
      .h_cnt   (h_cnt),
      .v_cnt   (v_cnt),
      .de      (de),
      .rd_addr (rd_addr),
      .rd_data (rd_data),
      .rgb     (rgb)
   );

   // Known image content, including an all-zero and an all-one word
   function automatic logic [WW-1:0] img_word(int a);
      int t;
      if (a == 5) return '0;
      if (a == 6) return '1;
      t = a * 40503 + 12345;
      return WW'(t ^ (a << 7));
   endfunction

   // RAM read port model: one clock of latency
   always @(posedge clk) rd_data <= img_word(int'(rd_addr));

   assign de = (int'(h_cnt) < HA) && (int'(v_cnt) < VA);

   // Free-running raster timing generator, starting in vertical blanking
   initial begin
      h_cnt = '0;
      v_cnt = VW'(VA + 1);
      forever begin
         @(posedge clk);
         if (int'(h_cnt) == HT - 1) begin
            h_cnt <= '0;
            v_cnt <= (int'(v_cnt) == VT - 1) ? '0 : v_cnt + 1'b1;
         end else begin
            h_cnt <= h_cnt + 1'b1;
         end
      end
   end

   task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s: actual %h expected %h (t=%0t)", tag, act, exp, $time);
      end
   endtask

   // Behavioural reference model, compared on every clock
   int  prev_h = 0;
   int  prev_v = 0;
   bit  prev_de = 0;
   bit  prev_rstn = 0;
   logic [AW-1:0] prev_addr = '0;
   bit  synced = 0;
   bit  post_rst = 0;
   int  frames_seen = 0;
   logic [23:0] ref_pix = '0;

   always @(negedge clk) begin
      logic [WW-1:0] w;
      logic          b;
      logic [23:0]   exp_rgb;
      string         tag;
      if (!rst_n) begin
         check("R1 rgb", 32'(rgb), 32'h0);
         check("R1 addr", 32'(rd_addr), 32'h0);
         synced = 0;
      end else if (prev_rstn) begin
         if (prev_v >= VA) synced = 1;
         check("R6", 32'(rd_addr < AW'(FW)), 32'h1);
         if (prev_v >= VA) check("R8", 32'(rd_addr), 32'h0);
         if (!prev_de && prev_v < VA) check("R7", 32'(rd_addr), 32'(prev_addr));
         if (!prev_de) begin
            check("R4", 32'(rgb), 32'h0);
         end else if (synced) begin
            w = img_word(prev_v * LW + prev_h / WW);
            b = w[prev_h % WW];
            exp_rgb = b ? 24'h0000FF : 24'h00FF00;
            if (post_rst)             tag = "R11/R5";
            else if (prev_h == 0)     tag = "R10/R5";
            else if (!b)              tag = "R3/R5";
            else                      tag = "R2/R5";
            check(tag, 32'(rgb), 32'(exp_rgb));
            if (prev_h == 17 && prev_v == 3) begin
               if (frames_seen == 0) ref_pix = rgb;
               else check("R9 frame-to-frame", 32'(rgb), 32'(ref_pix));
               frames_seen++;
            end
         end
      end
      prev_h    = int'(h_cnt);
      prev_v    = int'(v_cnt);
      prev_de   = de;
      prev_rstn = rst_n;
      prev_addr = rd_addr;
   end

   initial begin
      rst_n = 1'b1;
      #1 rst_n = 1'b0;
      repeat (4) @(negedge clk);
      #1 rst_n = 1'b1;
      repeat (4 * FRAME_CYC) @(negedge clk);
      // Reset in the middle of an active line
      while (!(int'(v_cnt) == 2 && int'(h_cnt) == 10)) @(negedge clk);
      #1 rst_n = 1'b0;
      post_rst = 1;
      repeat (6) @(negedge clk);
      #1 rst_n = 1'b1;
      repeat (3 * FRAME_CYC) @(negedge clk);
      check("R9 frames observed", 32'(frames_seen >= 5), 32'h1);
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, failures);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, failures);
         $finish;
      end
   end

endmodule